// File: doc/BRIEF.md
# Embedded Transmit Command Repeater

This block sits between a host transmit byte FIFO and the character transmitter of one X.21 channel. When its enable option is set, it looks at every byte leaving the FIFO for a four-byte command that starts with 0x80. A command sets the state of the C lead and repeats one data character. The C lead changes exactly when the first copy of that character reaches the transmitter, so data that was queued earlier still goes out under the previous C-lead state.

A nonzero count sends the character that many times. A count of zero keeps sending it until the FIFO presents another byte. Even then, at least three copies go out. All bytes outside a command pass to the transmitter unchanged. When the option is clear, every byte passes through untouched, including 0x80.

Both sides are byte-wide valid/ready links. A one-entry output stage holds the character offered to the transmitter.

Top module: `etc_repeater`

## Requirements
- R1: The option register resets to 0x00. Bit 5 is the command enable; it is written through `cfg_we_i`/`cfg_wdata_i`. All other bits read as zero.
- R2: With the enable clear, every accepted FIFO byte, including 0x80, appears unchanged and in order on `tx_data_o`.
- R3: With the enable set, bytes outside a command pass unchanged and in order. The four command bytes themselves are never forwarded.
- R4: Command byte 2 equal to 0x00 drives `c_lead_o` low (OFF). A value of 0x01 drives it high (ON). `c_lead_o` resets low.
- R5: `c_lead_o` changes only at the clock edge where the first copy of the command's character is loaded onto `tx_data_o`. This happens after earlier queued data has been taken by the transmitter.
- R6: A count byte N of 1 to 255 sends the character exactly N times. Normal forwarding of later FIFO bytes then resumes.
- R7: A count byte of 0 sends the character at least three times. After that it keeps sending until `fifo_valid_i` is seen high, and then it stops.
- R8: A byte 2 value from 0x02 to 0xFF leaves `c_lead_o` unchanged and sets `cmd_err_o`, which holds until reset. The character is still sent.
- R9: Clearing the enable while a command is only partly collected discards it. The next byte is handled as a fresh byte.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold steady.
- R11: The value 0x80 in command bytes 2 to 4 has no start meaning. As byte 3, it is sent as a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Option register write strobe |
| cfg_wdata_i | input | 8 | Option register write data |
| cfg_rdata_o | output | 8 | Option register read value |
| fifo_valid_i | input | 1 | FIFO byte available |
| fifo_data_i | input | 8 | FIFO byte |
| fifo_ready_o | output | 1 | FIFO byte taken this cycle |
| tx_valid_o | output | 1 | Character offered to transmitter |
| tx_data_o | output | 8 | Character to transmit |
| tx_ready_i | input | 1 | Transmitter takes the character |
| c_lead_o | output | 1 | C lead state, high is ON |
| cmd_err_o | output | 1 | Sticky reserved C-lead code flag |

## Verification
The assertions assume that the FIFO holds `fifo_data_i` stable while `fifo_valid_i` is high and unaccepted. They also assume that option writes do not land in the same cycle as a bypass byte whose forwarding is being checked. The bench source presents each byte at a falling edge and keeps it until it sees `fifo_ready_o`. Option writes happen only between byte pushes. The C-lead alignment property relies on the transmitter taking data only through `tx_ready_i`. The bench therefore changes `tx_ready_i` only at falling edges.

// File: rtl/etc_pkg.sv
package etc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTL,
    ST_CHR,
    ST_CNT,
    ST_REP
  } etc_state_e;
endpackage

// File: rtl/etc_opt_reg.sv
module etc_opt_reg #(
  parameter int REG_W  = 8,
  parameter int EN_BIT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             en_o,
  output logic [REG_W-1:0] rdata_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= 1'b0;
    else if (we_i) en_q <= wdata_i[EN_BIT];
  end

  always_comb begin
    rdata_o         = '0;
    rdata_o[EN_BIT] = en_q;
  end

  assign en_o = en_q;
endmodule

// File: rtl/etc_tx_stage.sv
module etc_tx_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              slot_free_o
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      dat_q <= data_i;
    end else if (tx_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign slot_free_o = !vld_q || tx_ready_i;
  assign tx_valid_o  = vld_q;
  assign tx_data_o   = dat_q;
endmodule

// File: rtl/etc_rep_ctr.sv
module etc_rep_ctr #(
  parameter int CNT_W    = 8,
  parameter int MIN_CONT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             done_o,
  output logic             last_o,
  output logic             cont_o
);
  localparam logic [CNT_W-1:0] MinCnt = CNT_W'(MIN_CONT);

  logic [CNT_W-1:0] cnt_q;
  logic             cont_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cont_q <= 1'b0;
    end else if (load_i) begin
      // zero count selects endless mode with a floor of MIN_CONT sends
      cont_q <= (count_i == '0);
      cnt_q  <= (count_i == '0) ? MinCnt : count_i;
    end else if (dec_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
  assign last_o = (cnt_q == CNT_W'(1));
  assign cont_o = cont_q;
endmodule

// File: rtl/etc_parser.sv
module etc_parser
  import etc_pkg::*;
#(
  parameter int                 DATA_W     = 8,
  parameter logic [DATA_W-1:0]  START_CODE = DATA_W'(128)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fifo_valid_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_ready_o,
  input  logic              slot_free_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_load_data_o,
  input  logic              cnt_done_i,
  input  logic              cnt_last_i,
  input  logic              cnt_cont_i,
  output logic              ctr_load_o,
  output logic              ctr_dec_o,
  output logic              c_lead_o,
  output logic              cmd_err_o
);
  etc_state_e        st_q, st_d;
  logic [DATA_W-1:0] chr_q;
  logic              c_q, c_next_q, first_q, err_q;
  logic              rep_fire, accept, ctl_rsvd;

  assign accept   = fifo_valid_i && fifo_ready_o;
  assign ctl_rsvd = (fifo_data_i[DATA_W-1:1] != '0);

  always_comb begin
    st_d           = st_q;
    fifo_ready_o   = 1'b0;
    tx_load_o      = 1'b0;
    tx_load_data_o = fifo_data_i;
    ctr_load_o     = 1'b0;
    ctr_dec_o      = 1'b0;
    rep_fire       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en_i && fifo_valid_i && fifo_data_i == START_CODE) begin
          fifo_ready_o = 1'b1;
          st_d         = ST_CTL;
        end else begin
          fifo_ready_o = slot_free_i;
          tx_load_o    = fifo_valid_i && slot_free_i;
        end
      end
      ST_CTL: begin
        if (!en_i) st_d = ST_IDLE;
        else begin
          fifo_ready_o = 1'b1;
          if (fifo_valid_i) st_d = ST_CHR;
        end
      end
      ST_CHR: begin
        if (!en_i) st_d = ST_IDLE;
        else begin
          fifo_ready_o = 1'b1;
          if (fifo_valid_i) st_d = ST_CNT;
        end
      end
      ST_CNT: begin
        if (!en_i) st_d = ST_IDLE;
        else begin
          fifo_ready_o = 1'b1;
          if (fifo_valid_i) begin
            st_d       = ST_REP;
            ctr_load_o = 1'b1;
          end
        end
      end
      ST_REP: begin
        // endless mode ends once the floor is met and new data waits
        if (cnt_done_i && cnt_cont_i && fifo_valid_i) begin
          st_d = ST_IDLE;
        end else if (slot_free_i) begin
          tx_load_o      = 1'b1;
          tx_load_data_o = chr_q;
          rep_fire       = 1'b1;
          ctr_dec_o      = !cnt_done_i;
          if (!cnt_cont_i && cnt_last_i) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      chr_q    <= '0;
      c_q      <= 1'b0;
      c_next_q <= 1'b0;
      first_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CTL && accept) begin
        if (ctl_rsvd) begin
          err_q    <= 1'b1;
          c_next_q <= c_q;
        end else begin
          c_next_q <= fifo_data_i[0];
        end
      end
      if (st_q == ST_CHR && accept) chr_q <= fifo_data_i;
      if (ctr_load_o) first_q <= 1'b1;
      else if (rep_fire && first_q) begin
        first_q <= 1'b0;
        c_q     <= c_next_q;
      end
    end
  end

  assign c_lead_o  = c_q;
  assign cmd_err_o = err_q;
endmodule

// File: rtl/etc_repeater.sv
module etc_repeater #(
  parameter int                DATA_W     = 8,
  parameter int                REG_W      = 8,
  parameter int                EN_BIT     = 5,
  parameter int                MIN_CONT   = 3,
  parameter logic [DATA_W-1:0] START_CODE = DATA_W'(128)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              fifo_valid_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              c_lead_o,
  output logic              cmd_err_o
);
  logic              en;
  logic              slot_free, tx_load;
  logic [DATA_W-1:0] tx_load_data;
  logic              ctr_load, ctr_dec, cnt_done, cnt_last, cnt_cont;

  etc_opt_reg #(.REG_W(REG_W), .EN_BIT(EN_BIT)) u_opt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .en_o    (en),
    .rdata_o (cfg_rdata_o)
  );

  etc_parser #(.DATA_W(DATA_W), .START_CODE(START_CODE)) u_parser (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en),
    .fifo_valid_i   (fifo_valid_i),
    .fifo_data_i    (fifo_data_i),
    .fifo_ready_o   (fifo_ready_o),
    .slot_free_i    (slot_free),
    .tx_load_o      (tx_load),
    .tx_load_data_o (tx_load_data),
    .cnt_done_i     (cnt_done),
    .cnt_last_i     (cnt_last),
    .cnt_cont_i     (cnt_cont),
    .ctr_load_o     (ctr_load),
    .ctr_dec_o      (ctr_dec),
    .c_lead_o       (c_lead_o),
    .cmd_err_o      (cmd_err_o)
  );

  etc_rep_ctr #(.CNT_W(DATA_W), .MIN_CONT(MIN_CONT)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ctr_load),
    .count_i (fifo_data_i),
    .dec_i   (ctr_dec),
    .done_o  (cnt_done),
    .last_o  (cnt_last),
    .cont_o  (cnt_cont)
  );

  etc_tx_stage #(.DATA_W(DATA_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tx_load),
    .data_i      (tx_load_data),
    .tx_ready_i  (tx_ready_i),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .slot_free_o (slot_free)
  );
endmodule

// File: rtl/etc_repeater_chk.sv
module etc_repeater_chk #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 8,
  parameter int EN_BIT = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [REG_W-1:0]  cfg_wdata_i,
  input logic [REG_W-1:0]  cfg_rdata_o,
  input logic              fifo_valid_i,
  input logic [DATA_W-1:0] fifo_data_i,
  input logic              fifo_ready_o,
  input logic              tx_valid_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_ready_i,
  input logic              c_lead_o,
  input logic              cmd_err_o
);
  assert_opt_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o[EN_BIT] == $past(cfg_wdata_i[EN_BIT]));

  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[EN_BIT] && fifo_valid_i && fifo_ready_o)
      |=> (tx_valid_o && tx_data_o == $past(fifo_data_i)));

  assert_c_lead_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(c_lead_o) |-> (tx_valid_o && !$past(fifo_valid_i && fifo_ready_o)));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> cmd_err_o);

  assert_tx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

bind etc_repeater etc_repeater_chk #(
  .DATA_W (DATA_W),
  .REG_W  (REG_W),
  .EN_BIT (EN_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .fifo_valid_i (fifo_valid_i),
  .fifo_data_i  (fifo_data_i),
  .fifo_ready_o (fifo_ready_o),
  .tx_valid_o   (tx_valid_o),
  .tx_data_o    (tx_data_o),
  .tx_ready_i   (tx_ready_i),
  .c_lead_o     (c_lead_o),
  .cmd_err_o    (cmd_err_o)
);

// File: tb/tb_etc_repeater.sv
module tb_etc_repeater;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic [7:0] cfg_rdata_o;
  logic       fifo_valid_i = 1'b0;
  logic [7:0] fifo_data_i = 8'h00;
  logic       fifo_ready_o;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;
  logic       tx_ready_i = 1'b1;
  logic       c_lead_o;
  logic       cmd_err_o;

  always #10 clk = ~clk;

  etc_repeater dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .fifo_valid_i(fifo_valid_i), .fifo_data_i(fifo_data_i),
    .fifo_ready_o(fifo_ready_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .tx_ready_i(tx_ready_i), .c_lead_o(c_lead_o), .cmd_err_o(cmd_err_o)
  );

  typedef struct packed {
    logic            en;
    logic [3:0]      nin;
    logic [0:7][7:0] din;
    logic [3:0]      nout;
    logic [0:7][7:0] dout;
    logic            cfin;
    logic            efin;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // R2: disabled, command start passes through
    '{en:1'b0, nin:4'd4, din:64'h80014102_00000000, nout:4'd4, dout:64'h80014102_00000000, cfin:1'b0, efin:1'b0},
    // R3 R4 R6: data, then ON with three copies, then data
    '{en:1'b1, nin:4'd6, din:64'h41800155_03420000, nout:4'd5, dout:64'h41555555_42000000, cfin:1'b1, efin:1'b0},
    // R4 R6: OFF with a single copy
    '{en:1'b1, nin:4'd4, din:64'h80003301_00000000, nout:4'd1, dout:64'h33000000_00000000, cfin:1'b0, efin:1'b0},
    // R7: count zero with data waiting gives exactly three copies
    '{en:1'b1, nin:4'd5, din:64'h80016600_44000000, nout:4'd4, dout:64'h66666644_00000000, cfin:1'b1, efin:1'b0},
    // R8: reserved C code
    '{en:1'b1, nin:4'd4, din:64'h80072102_00000000, nout:4'd2, dout:64'h21210000_00000000, cfin:1'b0, efin:1'b1},
    // R11: 0x80 as character
    '{en:1'b1, nin:4'd4, din:64'h80018002_00000000, nout:4'd2, dout:64'h80800000_00000000, cfin:1'b1, efin:1'b0},
    // R4 R6: back to back commands
    '{en:1'b1, nin:4'd8, din:64'h80015A02_80005B01, nout:4'd3, dout:64'h5A5A5B00_00000000, cfin:1'b0, efin:1'b0}
  };

  int n_chk = 0;
  int n_fail = 0;
  logic       cap_on = 1'b0;
  int         n_cap = 0;
  logic [7:0] cap [0:63];

  always @(negedge clk) begin
    #2;
    if (cap_on && tx_valid_o && tx_ready_i && n_cap < 64) begin
      cap[n_cap] = tx_data_o;
      n_cap++;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    fifo_valid_i = 1'b0;
    cfg_we_i = 1'b0;
    tx_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we_i = 1'b1;
    cfg_wdata_i = v;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    logic got;
    fifo_valid_i = 1'b1;
    fifo_data_i = b;
    forever begin
      #1;
      got = fifo_ready_o;
      @(negedge clk);
      if (got) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 R4: reset state
    chk(cfg_rdata_o == 8'h00, "R1 reset", cfg_rdata_o, 8'h00);
    chk(c_lead_o == 1'b0, "R4 reset", c_lead_o, 0);
    chk(tx_valid_o == 1'b0, "R3 reset valid", tx_valid_o, 0);
    chk(cmd_err_o == 1'b0, "R8 reset", cmd_err_o, 0);
    cfg_write(8'hFF);
    chk(cfg_rdata_o == 8'h20, "R1 readback", cfg_rdata_o, 8'h20);
    cfg_write(8'hDF);
    chk(cfg_rdata_o == 8'h00, "R1 clear", cfg_rdata_o, 8'h00);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      cfg_write(VECS[v].en ? 8'h20 : 8'h00);
      n_cap = 0;
      cap_on = 1'b1;
      for (int i = 0; i < int'(VECS[v].nin); i++) push(VECS[v].din[i]);
      fifo_valid_i = 1'b0;
      repeat (20) @(negedge clk);
      cap_on = 1'b0;
      chk(n_cap == int'(VECS[v].nout), "R3 R6 R7 count", n_cap, VECS[v].nout);
      for (int i = 0; i < int'(VECS[v].nout); i++)
        chk(cap[i] == VECS[v].dout[i], "R2 R3 R11 data", cap[i], VECS[v].dout[i]);
      chk(c_lead_o == VECS[v].cfin, "R4 R8 c lead", c_lead_o, VECS[v].cfin);
      chk(cmd_err_o == VECS[v].efin, "R8 err", cmd_err_o, VECS[v].efin);
    end

    // R5 R10: C lead waits for earlier queued byte
    do_reset();
    cfg_write(8'h20);
    tx_ready_i = 1'b0;
    push(8'h41); push(8'h80); push(8'h01); push(8'h77); push(8'h01);
    fifo_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_valid_o && tx_data_o == 8'h41, "R10 hold", tx_data_o, 8'h41);
    chk(c_lead_o == 1'b0, "R5 early", c_lead_o, 0);
    tx_ready_i = 1'b1;
    @(negedge clk);
    chk(tx_valid_o && tx_data_o == 8'h77, "R5 char", tx_data_o, 8'h77);
    chk(c_lead_o == 1'b1, "R5 aligned", c_lead_o, 1);
    @(negedge clk);
    chk(tx_valid_o == 1'b0, "R6 single", tx_valid_o, 0);

    // R7: endless repeat until data shows up
    do_reset();
    cfg_write(8'h20);
    n_cap = 0;
    cap_on = 1'b1;
    push(8'h80); push(8'h01); push(8'h66); push(8'h00);
    fifo_valid_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_cap >= 15, "R7 endless", n_cap, 15);
    push(8'h44);
    fifo_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    cap_on = 1'b0;
    chk(n_cap > 0 && cap[n_cap-1] == 8'h44, "R7 stop", cap[n_cap-1], 8'h44);
    chk(n_cap > 1 && cap[n_cap-2] == 8'h66, "R7 last copy", cap[n_cap-2], 8'h66);

    // R9: disable mid-command discards partial command
    do_reset();
    cfg_write(8'h20);
    n_cap = 0;
    cap_on = 1'b1;
    push(8'h80); push(8'h01);
    fifo_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    cfg_write(8'h00);
    repeat (2) @(negedge clk);
    push(8'h42);
    fifo_valid_i = 1'b0;
    cfg_write(8'h20);
    push(8'h43);
    fifo_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    cap_on = 1'b0;
    chk(n_cap == 2, "R9 count", n_cap, 2);
    chk(cap[0] == 8'h42 && cap[1] == 8'h43, "R9 data", {cap[0], cap[1]}, 16'h4243);
    chk(c_lead_o == 1'b0, "R9 c lead", c_lead_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule